// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block is the control and status register bank of a clock root generator. Software writes a source select, a divider field, a mode and three fractional counter values (M, N, D) into staged copies. None of these values reaches the divider datapath when it is written. Software then sets the update-request bit in the command register. After a fixed number of cycles the block copies every staged register into the active configuration at one clock edge. It clears the request bit and pulses a load strobe to the datapath. Software polls the request bit to see that the update is done. The command register also carries a root enable request, a root-off status bit, and one read-only flag per staged register. Each flag shows a pending write whose value differs from the one in use.

The bus side is a plain synchronous register port. A write is accepted on any clock edge where the write strobe is high, so the port has no back-pressure and no handshake. Read data is a combinational function of the address. The active configuration leaves the block as plain level outputs, together with a one-cycle load strobe.

Top module: `clkroot_regbank`

## Requirements
- R1: After reset, every staged and active register is zero (source 0, divider 0, mode 0, M/N/D 0), the enable request is 0, the load strobe is low, and the command register reads 0x8000_0000.
- R2: Registers sit at byte offsets 0x00 (command), 0x04 (configuration), 0x08 (M), 0x0C (N) and 0x10 (D). Any other address, including unaligned ones such as 0x05, reads zero, and writes to it change no register.
- R3: In the configuration register the divider field occupies bits DIV_W-1:0, the source select bits 10:8 and the mode bits 13:12. All other bits read zero and are not stored. M, N and D keep their low MND_W bits, and the upper bits read zero.
- R4: A write to a staged register changes its read value at once but leaves every active output unchanged until an update transfers it.
- R5: Writing the command register with bit 0 set starts an update. Bit 0 reads 1 for exactly UPD_LAT cycles after the write edge. On the edge that ends that window, all four staged registers are copied into the active outputs together, and bit 0 reads 0 from then on.
- R6: The load strobe is high for exactly one cycle, the cycle right after the transfer edge, and the active outputs already hold the new values in that cycle.
- R7: While an update is pending, a second request is ignored and does not restart the count, and writing 0 to bit 0 does not cancel it. One transfer happens, at the original time.
- R8: Command bits 4, 5, 6 and 7 are the change flags of the configuration, N, M and D registers. A write to a staged register sets its flag to whether the stored value differs from the active one, so writing back the active value clears it. All flags clear at the transfer edge.
- R9: If a staged register is written on the same edge as the transfer, the active side takes the previous staged value. The staged register keeps the new value, and its flag shows whether the new value differs from the value just transferred.
- R10: Command bit 1 is the root enable request and drives the root enable output from the edge of the write. Bit 31 reads the root-off status, which follows the inverse of the enable request one cycle later. Bits 31 and 7:4 ignore writes.
- R11: The dual-edge output is high exactly when the active mode field equals 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| root_en | output | 1 | Root enable request to the clock root |
| cfg_load | output | 1 | One-cycle strobe after the active configuration changes |
| act_div | output | DIV_W | Active divider field |
| act_src | output | 3 | Active source select |
| act_mode | output | 2 | Active counter mode |
| act_dual | output | 1 | Active mode is dual-edge |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
On every cycle the assertions check several properties. The pending window lasts exactly UPD_LAT cycles and cannot be cut short. Each transfer is followed by the load strobe. The active outputs move only with that strobe. The change flags clear on a transfer and hold when no write or transfer happens. The root-off status follows the enable one cycle late. Only the bench's scenarios can show the address map, the field masks, the exact values that land in the active outputs, the flag values after writes that match or differ from the active side, and the write that coincides with the transfer edge.

// File: rtl/clkroot_pkg.sv
package clkroot_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned NREG   = 4;

  // staged register slots; slot order equals change-flag order in the command word
  localparam int unsigned SLOT_CFG = 0;
  localparam int unsigned SLOT_N   = 1;
  localparam int unsigned SLOT_M   = 2;
  localparam int unsigned SLOT_D   = 3;

  // command word bit positions
  localparam int unsigned CMD_UPD_BIT   = 0;
  localparam int unsigned CMD_EN_BIT    = 1;
  localparam int unsigned CMD_FLAG_LSB  = 4;
  localparam int unsigned CMD_OFF_BIT   = 31;

  // configuration word fields
  localparam int unsigned CFG_SRC_LSB  = 8;
  localparam int unsigned CFG_SRC_W    = 3;
  localparam int unsigned CFG_MODE_LSB = 12;
  localparam int unsigned CFG_MODE_W   = 2;

  localparam logic [CFG_MODE_W-1:0] MODE_DUAL_EDGE = 2'd2;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t CMD_OFFSET = 32'h00;

  function automatic word_t slot_offset(input int unsigned slot);
    case (slot)
      SLOT_CFG: slot_offset = 32'h04;
      SLOT_M:   slot_offset = 32'h08;
      SLOT_N:   slot_offset = 32'h0C;
      default:  slot_offset = 32'h10;
    endcase
  endfunction

endpackage

// File: rtl/clkroot_shadow_bank.sv
module clkroot_shadow_bank
  import clkroot_pkg::*;
#(
  parameter logic [NREG*WORD_W-1:0] WMASK = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0]             wr_sel,
  input  word_t                       wdata,
  output logic [NREG-1:0][WORD_W-1:0] shadow_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam word_t KEEP = WMASK[i*WORD_W +: WORD_W];
    word_t stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
      end else if (wr_sel[i]) begin
        stage_q <= wdata & KEEP;
      end
    end

    assign shadow_o[i] = stage_q;
  end

endmodule

// File: rtl/clkroot_active_bank.sv
module clkroot_active_bank
  import clkroot_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NREG-1:0][WORD_W-1:0] shadow_i,
  output logic [NREG-1:0][WORD_W-1:0] active_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    word_t live_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= '0;
      end else if (load) begin
        live_q <= shadow_i[i];
      end
    end

    assign active_o[i] = live_q;
  end

endmodule

// File: rtl/clkroot_dirty_track.sv
module clkroot_dirty_track
  import clkroot_pkg::*;
#(
  parameter logic [NREG*WORD_W-1:0] WMASK = '1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NREG-1:0]             wr_sel,
  input  word_t                       wdata,
  input  logic                        load,
  input  logic [NREG-1:0][WORD_W-1:0] shadow_i,
  input  logic [NREG-1:0][WORD_W-1:0] active_i,
  output logic [NREG-1:0]             dirty_o
);

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    localparam word_t KEEP = WMASK[i*WORD_W +: WORD_W];
    word_t cmp_ref;
    logic  flag_q;

    // on a transfer edge the active side takes the staged value, so compare to it
    assign cmp_ref = load ? shadow_i[i] : active_i[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q <= 1'b0;
      end else if (wr_sel[i]) begin
        flag_q <= ((wdata & KEEP) != cmp_ref);
      end else if (load) begin
        flag_q <= 1'b0;
      end
    end

    assign dirty_o[i] = flag_q;
  end

endmodule

// File: rtl/clkroot_update_seq.sv
module clkroot_update_seq #(
  parameter int unsigned UPD_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pending,
  output logic load,
  output logic load_done
);

  localparam int unsigned CW = (UPD_LAT > 1) ? $clog2(UPD_LAT) : 1;

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load = pend_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= load;
      if (load) begin
        pend_q <= 1'b0;
      end else if (pend_q) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (req) begin
        pend_q <= 1'b1;
        cnt_q  <= CW'(UPD_LAT - 1);
      end
    end
  end

  assign pending   = pend_q;
  assign load_done = done_q;

endmodule

// File: rtl/clkroot_regbank.sv
module clkroot_regbank
  import clkroot_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned MND_W   = 8,
  parameter int unsigned UPD_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              root_en,
  output logic              cfg_load,
  output logic [DIV_W-1:0]  act_div,
  output logic [2:0]        act_src,
  output logic [1:0]        act_mode,
  output logic              act_dual,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);

  localparam word_t DIV_MASK  = word_t'((64'd1 << DIV_W) - 64'd1);
  localparam word_t SRC_MASK  = ((32'd1 << CFG_SRC_W) - 32'd1) << CFG_SRC_LSB;
  localparam word_t MODE_MASK = ((32'd1 << CFG_MODE_W) - 32'd1) << CFG_MODE_LSB;
  localparam word_t CFG_MASK  = DIV_MASK | SRC_MASK | MODE_MASK;
  localparam word_t MND_MASK  = word_t'((64'd1 << MND_W) - 64'd1);
  localparam logic [NREG*WORD_W-1:0] WMASK = {MND_MASK, MND_MASK, MND_MASK, CFG_MASK};

  logic                        cmd_hit;
  logic                        cmd_we;
  logic [NREG-1:0]             slot_hit;
  logic [NREG-1:0]             wr_sel;
  logic [NREG-1:0][WORD_W-1:0] shadow;
  logic [NREG-1:0][WORD_W-1:0] active;
  logic [NREG-1:0]             dirty;
  logic                        upd_req;
  logic                        upd_pending;
  logic                        upd_load;
  logic                        en_q;
  logic                        off_q;

  // address decode
  assign cmd_hit = (bus_addr == ADDR_W'(CMD_OFFSET));
  assign cmd_we  = bus_we && cmd_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam word_t OFS = slot_offset(i);
    assign slot_hit[i] = (bus_addr == OFS[ADDR_W-1:0]);
  end

  assign wr_sel  = slot_hit & {NREG{bus_we}};
  assign upd_req = cmd_we && bus_wdata[CMD_UPD_BIT];

  clkroot_shadow_bank #(
    .WMASK(WMASK)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wdata   (bus_wdata),
    .shadow_o(shadow)
  );

  clkroot_update_seq #(
    .UPD_LAT(UPD_LAT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (upd_req),
    .pending  (upd_pending),
    .load     (upd_load),
    .load_done(cfg_load)
  );

  clkroot_active_bank u_active (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (upd_load),
    .shadow_i(shadow),
    .active_o(active)
  );

  clkroot_dirty_track #(
    .WMASK(WMASK)
  ) u_dirty (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel),
    .wdata   (bus_wdata),
    .load    (upd_load),
    .shadow_i(shadow),
    .active_i(active),
    .dirty_o (dirty)
  );

  // root enable request and its delayed off status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      off_q <= 1'b1;
    end else begin
      if (cmd_we) begin
        en_q <= bus_wdata[CMD_EN_BIT];
      end
      off_q <= ~en_q;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (cmd_hit) begin
      bus_rdata[CMD_UPD_BIT]                 = upd_pending;
      bus_rdata[CMD_EN_BIT]                  = en_q;
      bus_rdata[CMD_FLAG_LSB +: NREG]        = dirty;
      bus_rdata[CMD_OFF_BIT]                 = off_q;
    end
    for (int s = 0; s < NREG; s++) begin
      if (slot_hit[s]) begin
        bus_rdata = shadow[s];
      end
    end
  end

  assign root_en  = en_q;
  assign act_div  = active[SLOT_CFG][DIV_W-1:0];
  assign act_src  = active[SLOT_CFG][CFG_SRC_LSB +: CFG_SRC_W];
  assign act_mode = active[SLOT_CFG][CFG_MODE_LSB +: CFG_MODE_W];
  assign act_dual = (act_mode == MODE_DUAL_EDGE);
  assign act_m    = active[SLOT_M][MND_W-1:0];
  assign act_n    = active[SLOT_N][MND_W-1:0];
  assign act_d    = active[SLOT_D][MND_W-1:0];

endmodule

// File: rtl/clkroot_regbank_chk.sv
module clkroot_regbank_chk #(
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned MND_W   = 8,
  parameter int unsigned UPD_LAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pending,
  input logic             load,
  input logic             cfg_load,
  input logic             wr_any,
  input logic [3:0]       dirty,
  input logic             root_en,
  input logic             off_q,
  input logic [DIV_W-1:0] act_div,
  input logic [2:0]       act_src,
  input logic [1:0]       act_mode,
  input logic [MND_W-1:0] act_m,
  input logic [MND_W-1:0] act_n,
  input logic [MND_W-1:0] act_d
);

  // consecutive pending cycles, counted instead of a long $past window
  logic [7:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (pending) begin
      pcnt <= (pcnt == 8'hFF) ? pcnt : pcnt + 8'd1;
    end else begin
      pcnt <= '0;
    end
  end

  a_r5_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (pcnt < 8'(UPD_LAT)));

  a_r5_pend_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> (pcnt == 8'(UPD_LAT)));

  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_load && !pending));

  a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |-> $stable({act_div, act_src, act_mode, act_m, act_n, act_d}));

  a_r7_no_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !load) |=> pending);

  a_r8_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_any) |=> (dirty == 4'b0000));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !wr_any) |=> $stable(dirty));

  a_r10_off_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (off_q == !$past(root_en)));

endmodule

bind clkroot_regbank clkroot_regbank_chk #(
  .DIV_W  (DIV_W),
  .MND_W  (MND_W),
  .UPD_LAT(UPD_LAT)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pending (upd_pending),
  .load    (upd_load),
  .cfg_load(cfg_load),
  .wr_any  (|wr_sel),
  .dirty   (dirty),
  .root_en (root_en),
  .off_q   (off_q),
  .act_div (act_div),
  .act_src (act_src),
  .act_mode(act_mode),
  .act_m   (act_m),
  .act_n   (act_n),
  .act_d   (act_d)
);

// File: tb/sim_clkroot_regbank.sv
`timescale 1ns/1ps
module sim_clkroot_regbank;

  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned DIV_W   = 5;
  localparam int unsigned MND_W   = 8;
  localparam int unsigned UPD_LAT = 4;

  localparam logic [31:0] CFG_KEEP = 32'h0000_001F | 32'h0000_0700 | 32'h0000_3000;
  localparam logic [31:0] MND_KEEP = 32'h0000_00FF;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic              bus_we = 1'b0;
  logic [31:0]       bus_rdata;
  logic              root_en, cfg_load, act_dual;
  logic [DIV_W-1:0]  act_div;
  logic [2:0]        act_src;
  logic [1:0]        act_mode;
  logic [MND_W-1:0]  act_m, act_n, act_d;

  always #2 clk = ~clk;

  clkroot_regbank #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .MND_W(MND_W), .UPD_LAT(UPD_LAT)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .root_en(root_en),
    .cfg_load(cfg_load), .act_div(act_div), .act_src(act_src),
    .act_mode(act_mode), .act_dual(act_dual), .act_m(act_m),
    .act_n(act_n), .act_d(act_d)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  // bench model: slots 0 cfg, 1 n, 2 m, 3 d
  logic [31:0]  m_sh  [4];
  logic [31:0]  m_act [4];
  logic [3:0]   m_dirty;
  logic         m_en;
  logic [127:0] exp_q[$];

  function automatic logic [4:0] slot_addr(input int s);
    case (s)
      0: slot_addr = 5'h04;
      1: slot_addr = 5'h0C;
      2: slot_addr = 5'h08;
      default: slot_addr = 5'h10;
    endcase
  endfunction

  function automatic logic [31:0] slot_keep(input int s);
    slot_keep = (s == 0) ? CFG_KEEP : MND_KEEP;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_slot(input int s, input logic [31:0] d);
    bus_wr(slot_addr(s), d);
    m_sh[s]    = d & slot_keep(s);
    m_dirty[s] = (m_sh[s] != m_act[s]);
  endtask

  function automatic logic [31:0] exp_cmd(input logic pend, input logic off);
    exp_cmd = {off, 23'b0, m_dirty, 2'b00, m_en, pend};
  endfunction

  task automatic push_snapshot();
    exp_q.push_back({m_sh[3], m_sh[2], m_sh[1], m_sh[0]});
  endtask

  task automatic commit_model();
    for (int s = 0; s < 4; s++) m_act[s] = m_sh[s];
    m_dirty = 4'b0000;
  endtask

  // full update: request, wait out the window, commit the model
  task automatic do_update();
    bus_wr(5'h00, {30'b0, m_en, 1'b1});
    push_snapshot();
    idle(UPD_LAT);
    commit_model();
  endtask

  task automatic chk_active(input string req, input logic [127:0] e);
    chk(req, 32'(act_div),  32'(e[DIV_W-1:0]));
    chk(req, 32'(act_src),  32'(e[10:8]));
    chk(req, 32'(act_mode), 32'(e[13:12]));
    chk(req, 32'(act_n),    32'(e[32 +: MND_W]));
    chk(req, 32'(act_m),    32'(e[64 +: MND_W]));
    chk(req, 32'(act_d),    32'(e[96 +: MND_W]));
  endtask

  // monitor: every load strobe pops one expected configuration (R6)
  always @(negedge clk) begin
    if (rst_n && cfg_load) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected load strobe", 32'd1, 32'd0);
      end else begin
        chk_active("R5 transferred values", exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    for (int s = 0; s < 4; s++) begin
      m_sh[s]  = '0;
      m_act[s] = '0;
    end
    m_dirty = '0;
    m_en    = 1'b0;

    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    bus_rd(5'h00, rd); chk("R1 cmd", rd, 32'h8000_0000);
    for (int s = 0; s < 4; s++) begin
      bus_rd(slot_addr(s), rd); chk("R1 staged", rd, 32'h0);
    end
    chk_active("R1 active", '0);
    chk("R1 root_en", 32'(root_en), 32'd0);
    chk("R1 cfg_load", 32'(cfg_load), 32'd0);

    // R3 field masks
    wr_slot(0, 32'hFFFF_FFFF);
    bus_rd(5'h04, rd); chk("R3 cfg mask", rd, 32'h0000_371F);
    wr_slot(2, 32'hFFFF_FFA5);
    bus_rd(5'h08, rd); chk("R3 m mask", rd, 32'h0000_00A5);
    wr_slot(1, 32'h0000_1234);
    bus_rd(5'h0C, rd); chk("R3 n mask", rd, 32'h0000_0034);

    // R8 flags after writes, R4 outputs unchanged
    bus_rd(5'h00, rd); chk("R8 flags set", rd, exp_cmd(1'b0, 1'b1));
    chk("R8 flag pattern", rd[7:4] , 4'b0111);
    chk_active("R4 no early effect", '0);

    // R2 unmapped addresses
    bus_wr(5'h05, 32'hFFFF_FFFF);
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_rd(5'h05, rd); chk("R2 unaligned reads zero", rd, 32'h0);
    bus_rd(5'h14, rd); chk("R2 unmapped reads zero", rd, 32'h0);
    bus_rd(5'h04, rd); chk("R2 cfg untouched", rd, 32'h0000_371F);
    bus_rd(5'h10, rd); chk("R2 d untouched", rd, 32'h0);

    // R5 precise update timing
    bus_wr(5'h00, 32'h1);
    push_snapshot();
    bus_rd(5'h00, rd); chk("R5 pending set", rd, exp_cmd(1'b1, 1'b1));
    idle(UPD_LAT - 1);
    bus_rd(5'h00, rd); chk("R5 pending last cycle", rd[0], 1'b1);
    chk_active("R4 held during window", '0);
    chk("R6 no strobe yet", 32'(cfg_load), 32'd0);
    idle(1);
    commit_model();
    bus_rd(5'h00, rd); chk("R5 pending cleared", rd, exp_cmd(1'b0, 1'b1));
    chk("R6 strobe high", 32'(cfg_load), 32'd1);
    chk("R11 mode 3 not dual", 32'(act_dual), 32'd0);
    idle(1);
    chk("R6 strobe one cycle", 32'(cfg_load), 32'd0);

    // R8 flag follows comparison with the active value
    wr_slot(2, 32'h0000_00A5);
    bus_rd(5'h00, rd); chk("R8 equal write clean", rd[6], 1'b0);
    wr_slot(2, 32'h0000_0011);
    bus_rd(5'h00, rd); chk("R8 differing write dirty", rd[6], 1'b1);
    wr_slot(2, 32'h0000_00A5);
    bus_rd(5'h00, rd); chk("R8 write back clears", rd[6], 1'b0);

    // R11 dual-edge mode, plus D register
    wr_slot(0, 32'h0000_2203);
    wr_slot(3, 32'h0000_00C3);
    do_update();
    chk("R11 dual high", 32'(act_dual), 32'd1);
    bus_rd(5'h00, rd); chk("R8 flags cleared", rd, exp_cmd(1'b0, 1'b1));

    // R7 repeated request and cancel attempt
    wr_slot(1, 32'h0000_0077);
    bus_wr(5'h00, 32'h1);
    push_snapshot();
    bus_wr(5'h00, 32'h0);
    bus_wr(5'h00, 32'h1);
    bus_rd(5'h00, rd); chk("R7 still pending", rd[0], 1'b1);
    idle(1);
    bus_rd(5'h00, rd); chk("R7 pending at last cycle", rd[0], 1'b1);
    idle(1);
    commit_model();
    bus_rd(5'h00, rd); chk("R7 done at original time", rd[0], 1'b0);
    chk("R7 n applied", 32'(act_n), 32'h77);
    idle(UPD_LAT + 1);
    bus_rd(5'h00, rd); chk("R7 no second update", rd[0], 1'b0);

    // R9 write on the transfer edge
    wr_slot(2, 32'h0000_005A);
    bus_wr(5'h00, 32'h1);
    push_snapshot();
    idle(UPD_LAT - 1);
    bus_wr(5'h08, 32'h0000_003C);
    chk("R9 active takes old staged", 32'(act_m), 32'h5A);
    commit_model();
    m_sh[2]    = 32'h3C;
    m_dirty[2] = 1'b1;
    bus_rd(5'h08, rd); chk("R9 staged keeps new", rd, 32'h3C);
    bus_rd(5'h00, rd); chk("R9 flag vs transferred", rd, exp_cmd(1'b0, 1'b1));

    // R10 root enable and root-off status
    bus_wr(5'h00, 32'h2);
    m_en = 1'b1;
    chk("R10 root_en set", 32'(root_en), 32'd1);
    bus_rd(5'h00, rd); chk("R10 off still high", rd[31], 1'b1);
    idle(1);
    bus_rd(5'h00, rd); chk("R10 off low", rd, exp_cmd(1'b0, 1'b0));
    bus_wr(5'h00, 32'hFFFF_FFF0);
    m_en = 1'b0;
    chk("R10 root_en clear", 32'(root_en), 32'd0);
    bus_rd(5'h00, rd); chk("R10 read-only bits", rd, exp_cmd(1'b0, 1'b0));
    idle(1);
    bus_rd(5'h00, rd); chk("R10 off back high", rd, exp_cmd(1'b0, 1'b1));

    idle(2);
    chk("R6 all loads seen", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

endmodule